// File: doc/BRIEF.md
# Output-Side Switch Allocator with Free-VC Selection

This block is the back half of a two-stage mesh router pipeline with five ports (north, south, west, east, local). Each input offers the flit that won its own input-side arbitration, together with that flit's input VC and, for a packet's first flit, the computed output port. The block decides whether the flit may enter that input's pipeline register. In the following cycle it arbitrates, per output port, among the occupied pipeline registers that target that port, and drives the winner onto the output link.

A separate VC-allocation stage is not used. Each output port keeps a FIFO of downstream VC ids that are currently unused. A packet-opening flit (head or single) that enters a pipeline register takes the id at the front of its output's FIFO. The flit is sent with its VC field rewritten to that id, and the id is recorded for the packet's input VC. Body and tail flits reuse the recorded output port and VC. An id goes back to the rear of its FIFO when the flit that closes the packet (tail or single) is sent on that output.

Top module: `swalloc_vcsel`

## Requirements
- R1: After a synchronous reset every output link is idle and no input is accepted or leaving. Every free-VC FIFO holds the ids 0 to V-1, with id 0 at the front.
- R2: Flit kinds are encoded as 0 head, 1 body, 2 tail and 3 single. Output ports are numbered 0 north, 1 south, 2 west, 3 east and 4 local. A head or single flit that is accepted takes the front id of its output's FIFO, and it is sent with that id in its VC field.
- R3: In any cycle, at most one head or single flit per output port is accepted. When several inputs compete, a round-robin granter per output picks one, and after reset the lowest input index has priority.
- R4: A head or single flit is not accepted while its output's free-VC FIFO is empty.
- R5: Body and tail flits ignore the offered route. They travel to the output and carry the VC recorded for their input and input VC. The granter and the FIFO state do not limit them.
- R6: When a tail or single flit is transferred on an output, its VC id is appended to the rear of that output's FIFO. Ids are therefore handed out again in FIFO order.
- R7: A flit accepted in one cycle is presented on its target output link in the next cycle. Each output link only considers pipeline registers whose recorded target is that output.
- R8: Each output's link arbiter is round-robin over the five inputs, with the lowest index first after reset. Its pointer moves only on a completed transfer, which needs both valid and ready.
- R9: While an output is not ready, the pipeline register feeding it keeps its flit unchanged. No leave is signalled for that input and no new flit is accepted into it.
- R10: A pipeline register whose flit is leaving can accept a new flit in the same cycle, so one input can send flits back to back.
- R11: leave[i] is high exactly when input i's registered flit is transferred on some output in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_valid | input | 5 | Input-side winner present, one bit per input |
| fs_kind | input | 5*2 | Flit kind per input (0 head, 1 body, 2 tail, 3 single) |
| fs_ivc | input | 5*VW | Input VC of the offered flit |
| fs_route | input | 5*3 | Output port for head/single flits (ignored for body/tail) |
| fs_data | input | 5*DATA_W | Flit payload |
| fs_accept | output | 5 | Offered flit enters the pipeline register at this edge |
| leave | output | 5 | Pipeline register of this input is transferred this cycle |
| lk_valid | output | 5 | Output link carries a flit |
| lk_kind | output | 5*2 | Kind of the flit on each output link |
| lk_vc | output | 5*VW | Downstream VC id on each output link |
| lk_data | output | 5*DATA_W | Payload on each output link |
| lk_ready | input | 5 | Downstream can take the flit on this output |

## Verification
Some checks run on every cycle. At most one grant is given per arbiter, and only to a requester. No id is taken from an empty FIFO, and no FIFO overflows. A stalled pipeline register holds its contents, and leave never fires for an empty register. Other properties only show up across several cycles, so the bench's scenarios cover them. These are the order in which ids come back out of each FIFO, the round-robin turn-taking on a shared output, the way body flits follow the recorded route and VC, the one-cycle latency, and back-to-back reloading. The bench also sweeps every input-to-output pair with single-flit packets.

// File: rtl/swa_pkg.sv
package swa_pkg;
  localparam int NPORT = 5;
  localparam int PW    = 3;

  typedef enum logic [1:0] {
    FL_HEAD   = 2'd0,
    FL_BODY   = 2'd1,
    FL_TAIL   = 2'd2,
    FL_SINGLE = 2'd3
  } flit_kind_e;

  function automatic logic opens_pkt(input logic [1:0] k);
    return (k == FL_HEAD) || (k == FL_SINGLE);
  endfunction

  function automatic logic closes_pkt(input logic [1:0] k);
    return (k == FL_TAIL) || (k == FL_SINGLE);
  endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last;
  logic [IW-1:0] gidx;
  logic          found;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last) + k) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    gidx = last;
    for (int k = 0; k < N; k++)
      if (gnt[k]) gidx = IW'(k);
  end

  always_ff @(posedge clk) begin
    if (rst)                last <= IW'(N - 1);
    else if (adv && |gnt)   last <= gidx;
  end

  // R8
  one_grant_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
  // R8
  grant_has_req_chk: assert property (@(posedge clk) disable iff (rst) (gnt & ~req) == '0);
endmodule

// File: rtl/free_vc_fifo.sv
module free_vc_fifo #(
  parameter int V = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  input  logic          push,
  input  logic [IW-1:0] push_id,
  output logic [IW-1:0] head_id,
  output logic          nonempty
);
  localparam int IW = (V > 1) ? $clog2(V) : 1;
  localparam int CW = $clog2(V + 1);

  logic [IW-1:0] mem [V];
  logic [IW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
    return (p == IW'(V - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_id  = mem[rd_ptr];
  assign nonempty = (count != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < V; k++) mem[k] <= IW'(k);
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= CW'(V);
    end else begin
      if (push) begin
        mem[wr_ptr] <= push_id;
        wr_ptr      <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (count < CW'(V)));
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
endmodule

// File: rtl/swalloc_vcsel.sv
module swalloc_vcsel import swa_pkg::*; #(
  parameter int NUM_VC = 2,
  parameter int DATA_W = 8,
  localparam int VW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NPORT-1:0]      fs_valid,
  input  logic [NPORT*2-1:0]    fs_kind,
  input  logic [NPORT*VW-1:0]   fs_ivc,
  input  logic [NPORT*PW-1:0]   fs_route,
  input  logic [NPORT*DATA_W-1:0] fs_data,
  output logic [NPORT-1:0]      fs_accept,
  output logic [NPORT-1:0]      leave,
  output logic [NPORT-1:0]      lk_valid,
  output logic [NPORT*2-1:0]    lk_kind,
  output logic [NPORT*VW-1:0]   lk_vc,
  output logic [NPORT*DATA_W-1:0] lk_data,
  input  logic [NPORT-1:0]      lk_ready
);
  localparam int NP = NPORT;

  typedef struct packed {
    logic [1:0]        kind;
    logic [VW-1:0]     vc;
    logic [PW-1:0]     tgt;
    logic [DATA_W-1:0] data;
  } preg_t;

  // pipeline registers and per-input-VC route state
  logic [NP-1:0] pv;
  preg_t         pr     [NP];
  logic [PW-1:0] st_tgt [NP][NUM_VC];
  logic [VW-1:0] st_ovc [NP][NUM_VC];

  // decoded offers
  logic [1:0]        kind_i  [NP];
  logic [VW-1:0]     ivc_i   [NP];
  logic [PW-1:0]     route_i [NP];
  logic [DATA_W-1:0] data_i  [NP];
  logic [NP-1:0]     opener, space;
  logic [VW-1:0]     ovc_new [NP];

  // arbitration vectors, indexed [output][input]
  logic [NP-1:0] hreq [NP];
  logic [NP-1:0] hgnt [NP];
  logic [NP-1:0] sreq [NP];
  logic [NP-1:0] sgnt [NP];

  // free-VC FIFOs
  logic [VW-1:0] q_head [NP];
  logic [NP-1:0] q_ne, q_pop, q_push;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      kind_i[i]  = fs_kind[i*2 +: 2];
      ivc_i[i]   = fs_ivc[i*VW +: VW];
      route_i[i] = fs_route[i*PW +: PW];
      data_i[i]  = fs_data[i*DATA_W +: DATA_W];
      opener[i]  = opens_pkt(kind_i[i]);
      leave[i]   = 1'b0;
      for (int o = 0; o < NP; o++)
        if (sgnt[o][i] && lk_ready[o]) leave[i] = 1'b1;
      space[i] = !pv[i] || leave[i];
    end
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        hreq[o][i] = fs_valid[i] && opener[i] && (route_i[i] == PW'(o))
                     && space[i] && q_ne[o];
  end

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      logic hg;
      hg         = 1'b0;
      ovc_new[i] = '0;
      for (int o = 0; o < NP; o++)
        if (hgnt[o][i]) begin
          hg         = 1'b1;
          ovc_new[i] = q_head[o];
        end
      fs_accept[i] = fs_valid[i] && space[i] && (!opener[i] || hg);
    end
  end

  always_comb begin
    for (int o = 0; o < NP; o++) begin
      for (int i = 0; i < NP; i++)
        sreq[o][i] = pv[i] && (pr[i].tgt == PW'(o));
    end
  end

  always_comb begin
    for (int o = 0; o < NP; o++) begin
      lk_valid[o]              = |sreq[o];
      lk_kind[o*2 +: 2]        = '0;
      lk_vc[o*VW +: VW]        = '0;
      lk_data[o*DATA_W +: DATA_W] = '0;
      for (int i = 0; i < NP; i++)
        if (sgnt[o][i]) begin
          lk_kind[o*2 +: 2]           = pr[i].kind;
          lk_vc[o*VW +: VW]           = pr[i].vc;
          lk_data[o*DATA_W +: DATA_W] = pr[i].data;
        end
      q_pop[o]  = |hgnt[o];
      q_push[o] = lk_valid[o] && lk_ready[o] && closes_pkt(lk_kind[o*2 +: 2]);
    end
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    rr_pick #(.N(NP)) u_head_gnt (
      .clk (clk),
      .rst (rst),
      .req (hreq[o]),
      .adv (1'b1),
      .gnt (hgnt[o])
    );

    rr_pick #(.N(NP)) u_link_arb (
      .clk (clk),
      .rst (rst),
      .req (sreq[o]),
      .adv (lk_ready[o]),
      .gnt (sgnt[o])
    );

    free_vc_fifo #(.V(NUM_VC)) u_free (
      .clk      (clk),
      .rst      (rst),
      .pop      (q_pop[o]),
      .push     (q_push[o]),
      .push_id  (lk_vc[o*VW +: VW]),
      .head_id  (q_head[o]),
      .nonempty (q_ne[o])
    );

    // R4
    pop_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
      (|hgnt[o]) |-> q_ne[o]);
    // R7
    link_has_source_chk: assert property (@(posedge clk) disable iff (rst)
      lk_valid[o] |-> (|sgnt[o]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pv <= '0;
      for (int i = 0; i < NP; i++) begin
        pr[i] <= '0;
        for (int v = 0; v < NUM_VC; v++) begin
          st_tgt[i][v] <= '0;
          st_ovc[i][v] <= '0;
        end
      end
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (fs_accept[i]) begin
          pv[i]         <= 1'b1;
          pr[i].kind    <= kind_i[i];
          pr[i].data    <= data_i[i];
          if (opener[i]) begin
            pr[i].vc                <= ovc_new[i];
            pr[i].tgt               <= route_i[i];
            st_tgt[i][ivc_i[i]]     <= route_i[i];
            st_ovc[i][ivc_i[i]]     <= ovc_new[i];
          end else begin
            pr[i].vc  <= st_ovc[i][ivc_i[i]];
            pr[i].tgt <= st_tgt[i][ivc_i[i]];
          end
        end else if (leave[i]) begin
          pv[i] <= 1'b0;
        end
      end
    end
  end

  for (genvar gi = 0; gi < NP; gi++) begin : g_in_chk
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (pv[gi] && !leave[gi]) |=> (pv[gi] && $stable(pr[gi])));
    // R11
    leave_needs_flit_chk: assert property (@(posedge clk) disable iff (rst)
      leave[gi] |-> pv[gi]);
  end
endmodule

// File: tb/sim_swalloc_vcsel.sv
module sim_swalloc_vcsel;
  localparam int CLK_NS = 10;
  localparam int NP = 5;
  localparam int V  = 2;
  localparam int VW = 1;
  localparam int DW = 8;
  localparam int K_HEAD = 0, K_BODY = 1, K_TAIL = 2, K_SINGLE = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0]    fs_valid;
  logic [NP*2-1:0]  fs_kind;
  logic [NP*VW-1:0] fs_ivc;
  logic [NP*3-1:0]  fs_route;
  logic [NP*DW-1:0] fs_data;
  logic [NP-1:0]    fs_accept, leave, lk_valid, lk_ready;
  logic [NP*2-1:0]  lk_kind;
  logic [NP*VW-1:0] lk_vc;
  logic [NP*DW-1:0] lk_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  swalloc_vcsel #(.NUM_VC(V), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst),
    .fs_valid(fs_valid), .fs_kind(fs_kind), .fs_ivc(fs_ivc),
    .fs_route(fs_route), .fs_data(fs_data), .fs_accept(fs_accept),
    .leave(leave), .lk_valid(lk_valid), .lk_kind(lk_kind), .lk_vc(lk_vc),
    .lk_data(lk_data), .lk_ready(lk_ready)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic clr();
    fs_valid = '0; fs_kind = '0; fs_ivc = '0; fs_route = '0; fs_data = '0;
  endtask

  task automatic put(input int i, input int k, input int ivc, input int tgt, input int d);
    fs_valid[i]        = 1'b1;
    fs_kind[i*2 +: 2]  = 2'(k);
    fs_ivc[i*VW +: VW] = VW'(ivc);
    fs_route[i*3 +: 3] = 3'(tgt);
    fs_data[i*DW +: DW] = DW'(d);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    clr();
    lk_ready = '1;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  function automatic int ld(input int o); return int'(lk_data[o*DW +: DW]); endfunction
  function automatic int lv(input int o); return int'(lk_vc[o*VW +: VW]); endfunction
  function automatic int lkk(input int o); return int'(lk_kind[o*2 +: 2]); endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 20000);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
    finish_run();
  end

  initial begin
    do_reset();
    // R1: idle after reset
    chk("R1 lk_valid", int'(lk_valid), 0);
    chk("R1 leave", int'(leave), 0);
    chk("R1 fs_accept", int'(fs_accept), 0);

    // Sweep: every input to every output, single-flit packets
    for (int o = 0; o < NP; o++) begin
      for (int i = 0; i < NP; i++) begin
        put(i, K_SINGLE, i % V, o, o*16 + i);
        #1;
        chk("R2 accept single", int'(fs_accept), 1 << i);
        tick();
        clr();
        #1;
        chk("R7 link valid", int'(lk_valid), 1 << o);
        chk("R7 link data", ld(o), o*16 + i);
        chk("R6 recycled vc order", lv(o), i % V);
        chk("R2 kind kept", lkk(o), K_SINGLE);
        chk("R11 leave", int'(leave), 1 << i);
        tick();
      end
    end

    // Scenario: FIFO exhaustion on output 1
    do_reset();
    put(0, K_HEAD, 0, 1, 8'h10);
    put(1, K_HEAD, 0, 1, 8'h11);
    #1;
    chk("R3 one head per output", int'(fs_accept), 5'b00001);
    tick();
    clr(); put(1, K_HEAD, 0, 1, 8'h11); #1;
    chk("R3 second head next cycle", int'(fs_accept), 5'b00010);
    chk("R2 head data", ld(1), 8'h10);
    chk("R2 head vc", lv(1), 0);
    chk("R2 head kind", lkk(1), K_HEAD);
    tick();
    clr(); put(2, K_HEAD, 0, 1, 8'h12); #1;
    chk("R4 blocked when empty", int'(fs_accept), 0);
    chk("R2 second vc", lv(1), 1);
    chk("R2 second data", ld(1), 8'h11);
    tick();
    put(0, K_TAIL, 0, 1, 8'h20); #1;
    chk("R5 tail accepted despite empty fifo", int'(fs_accept), 5'b00001);
    chk("R4 link idle", int'(lk_valid), 0);
    tick();
    clr(); put(2, K_HEAD, 0, 1, 8'h12); #1;
    chk("R4 still blocked", int'(fs_accept), 0);
    chk("R5 tail data", ld(1), 8'h20);
    chk("R5 tail vc", lv(1), 0);
    chk("R5 tail kind", lkk(1), K_TAIL);
    tick();
    #1;
    chk("R6 id returned, head accepted", int'(fs_accept), 5'b00100);
    tick();
    clr(); #1;
    chk("R6 returned id reused", lv(1), 0);
    chk("R6 data", ld(1), 8'h12);

    // Scenario: stall, round-robin link arbitration, back-to-back reload on output 2
    do_reset();
    lk_ready = 5'b11011;
    put(0, K_HEAD, 0, 2, 8'h30); #1;
    chk("R2 accept", int'(fs_accept), 5'b00001);
    tick();
    clr(); put(3, K_HEAD, 1, 2, 8'h33); #1;
    chk("R3 accept other input", int'(fs_accept), 5'b01000);
    chk("R9 link shows flit", ld(2), 8'h30);
    chk("R9 no leave when stalled", int'(leave), 0);
    tick();
    clr(); put(0, K_BODY, 0, 2, 8'h31); #1;
    chk("R9 full register refuses", int'(fs_accept), 0);
    chk("R9 flit held", ld(2), 8'h30);
    chk("R9 no leave", int'(leave), 0);
    tick();
    lk_ready = '1; #1;
    chk("R11 leave on transfer", int'(leave), 5'b00001);
    chk("R10 reload while leaving", int'(fs_accept), 5'b00001);
    chk("R8 lowest first", ld(2), 8'h30);
    tick();
    clr(); #1;
    chk("R8 rotates to other input", ld(2), 8'h33);
    chk("R8 vc", lv(2), 1);
    chk("R8 leave", int'(leave), 5'b01000);
    tick();
    chk("R10 back-to-back body", ld(2), 8'h31);
    chk("R5 body kind", lkk(2), K_BODY);
    chk("R5 body vc", lv(2), 0);
    chk("R10 leave", int'(leave), 5'b00001);
    tick();
    chk("R7 drained", int'(lk_valid), 0);

    // Scenario: parallel outputs, body alongside a head on a shared output
    do_reset();
    put(0, K_HEAD, 0, 4, 8'h40);
    put(1, K_HEAD, 0, 3, 8'h41); #1;
    chk("R3 two outputs in parallel", int'(fs_accept), 5'b00011);
    tick();
    clr();
    put(0, K_BODY, 0, 0, 8'h42);
    put(2, K_HEAD, 1, 4, 8'h43); #1;
    chk("R5 body not limited by granter", int'(fs_accept), 5'b00101);
    chk("R7 two links valid", int'(lk_valid), 5'b11000);
    chk("R7 data out4", ld(4), 8'h40);
    chk("R7 data out3", ld(3), 8'h41);
    chk("R11 two leave", int'(leave), 5'b00011);
    tick();
    clr(); #1;
    chk("R8 rr picks input 2", ld(4), 8'h43);
    chk("R2 second id", lv(4), 1);
    chk("R8 leave", int'(leave), 5'b00100);
    chk("R7 single link", int'(lk_valid), 5'b10000);
    tick();
    chk("R5 body follows recorded route", ld(4), 8'h42);
    chk("R5 body recorded vc", lv(4), 0);
    chk("R11 leave body", int'(leave), 5'b00001);
    tick();
    chk("R7 idle", int'(lk_valid), 0);

    finish_run();
  end
endmodule